// File: doc/BRIEF.md
# NAND Command Interface with Status

This block models the control side of a small NAND storage device. The host writes bytes over an 8-bit bus with a one-cycle write strobe. A command-latch qualifier marks a byte as a command, and an address-latch qualifier marks it as an address. The block decodes a block-erase sequence, a reset command and a status query. It drives a ready/busy line in the manner of an open-drain output: `rb_low` is high while the device pulls the line low. A small register array stands in for the storage cells.

An erase is set up by `60h`, followed by two address cycles, and is started by `D0h`. When the erase busy period ends, every word of the addressed block becomes `FFh`. Command `FFh` aborts a running erase. An aborted erase leaves a pseudo-random subset of the block's words at `FFh` and keeps the others. `FFh` also clears the command state and the status byte. A reset that arrives while the device is already in its reset state is not accepted. Command `70h` selects the status byte. The status byte then shows on `dout` while `rd_en` is high, and it follows internal changes without `rd_en` being toggled.

Top module: `nand_cmd_ctrl`

## Requirements
- R1: After `rst` the block is ready (`rb_low`=0) and `dout`=00h. Array word a holds a XOR 5Ah, where a = block*WORDS_PER_BLOCK + word. A later `70h` reads status 40h.
- R2: The sequence `60h`, address byte A, address byte 00h, `D0h` erases block A[1:0]. Bits 7:2 of A are ignored. At completion every word of that block reads FFh, and all other blocks are unchanged.
- R3: After the `D0h` write, `rb_low` stays high for exactly ERASE_CYC clock cycles. After the last of these the block is ready again.
- R4: If the second address byte is not 00h, the erase runs its full busy period and leaves the array unchanged. The status then reads 41h (bit 0 = fail). A valid erase leaves bit 0 = 0.
- R5: At the confirm step, any command other than `D0h` cancels the sequence. No busy period follows, and a later `D0h` has no effect.
- R6: `FFh` written during an erase aborts it, and `rb_low` stays high for RST_ERASE_CYC cycles. Each word of the target block is then either its old value or FFh. Other blocks are unchanged, and the status then reads 40h.
- R7: `FFh` written while idle and not in the reset state keeps `rb_low` high for RST_IDLE_CYC cycles and clears status bit 0.
- R8: `FFh` written while in the reset state (after `rst` or after a completed reset, with no `60h` since) is ignored: `rb_low` stays 0.
- R9: After `70h`, with `rd_en`=1, `dout` = {0, ready, 00000b, fail}. It tracks the busy-to-ready change with `rd_en` held high. `dout` is 00h when `rd_en`=0 or after `60h` deselects status.
- R10: A write with both `cle` and `ale` high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | One-cycle write strobe for `din` |
| cle | input | 1 | Marks the write as a command byte |
| ale | input | 1 | Marks the write as an address byte |
| din | input | 8 | Command or address byte |
| rd_en | input | 1 | Combined chip-select and read-enable, active high |
| dout | output | 8 | Status byte while selected, else 00h |
| rb_low | output | 1 | Ready/busy pull-low enable (1 = busy) |
| peek_addr | input | ADDR_W | Storage word index for inspection |
| peek_data | output | 8 | Content of the inspected word |

## Verification
The bench erases every block in turn. Each time it varies the ignored high bits of the first address byte and compares the whole array against an arithmetic model. A design that decoded the wrong address bits would wipe the wrong block and be caught. The bench counts busy cycles for the erase, for the idle reset and for the abort reset separately. A design that used a single reset duration, or was off by one cycle, shows up as a wrong count. The bench also goes after the accepted-or-ignored edges of the command set: a repeated reset in the reset state, a wrong confirm code, a nonzero second address byte and a write with both qualifiers high. A design that starts a busy period, corrupts storage or reports a stale fail bit in any of these cases fails a check. After an abort, each word of the target block must read either its old value or FFh. Status is held selected across an erase to show that it updates without a strobe.

// File: rtl/nand_ci_pkg.sv
package nand_ci_pkg;

    localparam int IO_W = 8;

    localparam logic [IO_W-1:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [IO_W-1:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [IO_W-1:0] OP_STATUS      = 8'h70;
    localparam logic [IO_W-1:0] OP_RESET       = 8'hFF;

    localparam logic [7:0] LFSR_SEED = 8'hA5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR1,
        ST_ADR2,
        ST_CONF,
        ST_ERASE,
        ST_RESET
    } ci_state_e;

    typedef struct packed {
        logic ready;
        logic fail;
    } ci_status_t;

    function automatic logic [IO_W-1:0] status_byte(ci_status_t s);
        return {1'b0, s.ready, 5'b00000, s.fail};
    endfunction

    function automatic logic [IO_W-1:0] init_word(int unsigned a);
        return IO_W'(a) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] lfsr_step(logic [7:0] x);
        return x[0] ? ((x >> 1) ^ 8'hB8) : (x >> 1);
    endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CNT_W'(1));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_store.sv
module nand_store
    import nand_ci_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int WORDS_PER_BLOCK = 8,
    localparam int NW     = NUM_BLOCKS * WORDS_PER_BLOCK,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int ADDR_W = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              corrupt,
    input  logic [BLK_W-1:0]  blk,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [IO_W-1:0]   peek_data
);
    logic [IO_W-1:0] mem [NW];
    logic [7:0]      lfsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr <= LFSR_SEED;
            for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
        end else begin
            lfsr <= lfsr_step(lfsr);
            for (int i = 0; i < NW; i++) begin
                if (i / WORDS_PER_BLOCK == int'(blk)) begin
                    if (wipe)
                        mem[i] <= '1;
                    else if (corrupt && lfsr[3'((i % WORDS_PER_BLOCK) % 8)])
                        mem[i] <= '1;
                end
            end
        end
    end

    assign peek_data = mem[peek_addr];

    for (genvar g = 0; g < NW; g++) begin : g_word_chk
        // R2
        wipe_ones_chk: assert property (@(posedge clk) disable iff (rst)
            (wipe && int'(blk) == g / WORDS_PER_BLOCK) |=> (mem[g] == '1));
        // R6
        abort_subset_chk: assert property (@(posedge clk) disable iff (rst)
            (corrupt && int'(blk) == g / WORDS_PER_BLOCK)
                |=> (mem[g] == '1 || mem[g] == $past(mem[g])));
        // R2
        other_intact_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(blk) != g / WORDS_PER_BLOCK) |=> $stable(mem[g]));
    end

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_ci_pkg::*;
#(
    parameter int ERASE_CYC     = 24,
    parameter int RST_IDLE_CYC  = 5,
    parameter int RST_ERASE_CYC = 12,
    parameter int BLK_W         = 2,
    parameter int CNT_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             cle,
    input  logic             ale,
    input  logic [IO_W-1:0]  din,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_len,
    output logic             wipe,
    output logic             corrupt,
    output logic [BLK_W-1:0] blk,
    output logic             busy,
    output logic             stat_mode,
    output ci_status_t       status
);
    ci_state_e        state, nxt_state;
    logic [BLK_W-1:0] nxt_blk;
    logic             addr_ok, nxt_ok;
    logic             fail, nxt_fail;
    logic             in_rst, nxt_inrst;
    logic             nxt_stat;
    logic             cmd_wr, adr_wr;

    assign cmd_wr = we && cle && !ale;
    assign adr_wr = we && ale && !cle;

    always_comb begin
        nxt_state = state;
        nxt_blk   = blk;
        nxt_ok    = addr_ok;
        nxt_fail  = fail;
        nxt_inrst = in_rst;
        nxt_stat  = stat_mode;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        wipe      = 1'b0;
        corrupt   = 1'b0;
        unique case (state)
            ST_ERASE: begin
                if (cmd_wr && din == OP_RESET) begin
                    corrupt   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_len   = CNT_W'(RST_ERASE_CYC);
                    nxt_state = ST_RESET;
                    nxt_fail  = 1'b0;
                    nxt_stat  = 1'b0;
                end else begin
                    if (cmd_wr && din == OP_STATUS) nxt_stat = 1'b1;
                    if (tmr_done) begin
                        wipe      = addr_ok;
                        nxt_fail  = !addr_ok;
                        nxt_state = ST_IDLE;
                    end
                end
            end
            ST_RESET: begin
                if (tmr_done) begin
                    nxt_state = ST_IDLE;
                    nxt_inrst = 1'b1;
                end
            end
            default: begin
                if (cmd_wr) begin
                    if (state == ST_CONF && din == OP_ERASE_GO) begin
                        tmr_load  = 1'b1;
                        tmr_len   = CNT_W'(ERASE_CYC);
                        nxt_state = ST_ERASE;
                    end else if (din == OP_ERASE_SETUP) begin
                        nxt_state = ST_ADR1;
                        nxt_inrst = 1'b0;
                        nxt_stat  = 1'b0;
                    end else if (din == OP_STATUS) begin
                        nxt_state = ST_IDLE;
                        nxt_stat  = 1'b1;
                    end else if (din == OP_RESET) begin
                        if (!in_rst) begin
                            tmr_load  = 1'b1;
                            tmr_len   = CNT_W'(RST_IDLE_CYC);
                            nxt_state = ST_RESET;
                            nxt_fail  = 1'b0;
                            nxt_stat  = 1'b0;
                        end
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end else if (adr_wr) begin
                    if (state == ST_ADR1) begin
                        nxt_blk   = din[BLK_W-1:0];
                        nxt_state = ST_ADR2;
                    end else if (state == ST_ADR2) begin
                        nxt_ok    = (din == '0);
                        nxt_state = ST_CONF;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            blk       <= '0;
            addr_ok   <= 1'b0;
            fail      <= 1'b0;
            in_rst    <= 1'b1;
            stat_mode <= 1'b0;
        end else begin
            state     <= nxt_state;
            blk       <= nxt_blk;
            addr_ok   <= nxt_ok;
            fail      <= nxt_fail;
            in_rst    <= nxt_inrst;
            stat_mode <= nxt_stat;
        end
    end

    assign busy         = (state == ST_ERASE) || (state == ST_RESET);
    assign status.ready = !busy;
    assign status.fail  = fail;

    // R8
    reset_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rst && state == ST_IDLE && cmd_wr && din == OP_RESET) |=> !busy);
    // R2
    erase_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ERASE && !(state == ST_CONF && cmd_wr && din == OP_ERASE_GO))
            |=> (state != ST_ERASE));
    // R6
    abort_to_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && cmd_wr && din == OP_RESET) |=> (state == ST_RESET && !fail));
    // R10
    dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (we && cle && ale && !busy) |=> (state == $past(state)));

endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
    import nand_ci_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int WORDS_PER_BLOCK = 8,
    parameter int ERASE_CYC       = 24,
    parameter int RST_IDLE_CYC    = 5,
    parameter int RST_ERASE_CYC   = 12,
    localparam int BLK_W   = $clog2(NUM_BLOCKS),
    localparam int ADDR_W  = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK),
    localparam int MAX_A   = (ERASE_CYC > RST_IDLE_CYC) ? ERASE_CYC : RST_IDLE_CYC,
    localparam int MAX_CYC = (MAX_A > RST_ERASE_CYC) ? MAX_A : RST_ERASE_CYC,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              cle,
    input  logic              ale,
    input  logic [7:0]        din,
    input  logic              rd_en,
    output logic [7:0]        dout,
    output logic              rb_low,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data
);
    logic             tmr_done, tmr_load, wipe, corrupt, busy, stat_mode;
    logic [CNT_W-1:0] tmr_len;
    logic [BLK_W-1:0] blk;
    ci_status_t       status;

    nand_cmd_fsm #(
        .ERASE_CYC    (ERASE_CYC),
        .RST_IDLE_CYC (RST_IDLE_CYC),
        .RST_ERASE_CYC(RST_ERASE_CYC),
        .BLK_W        (BLK_W),
        .CNT_W        (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .cle      (cle),
        .ale      (ale),
        .din      (din),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_len  (tmr_len),
        .wipe     (wipe),
        .corrupt  (corrupt),
        .blk      (blk),
        .busy     (busy),
        .stat_mode(stat_mode),
        .status   (status)
    );

    nand_busy_timer #(.CNT_W(CNT_W)) timer_i (
        .clk (clk),
        .rst (rst),
        .load(tmr_load),
        .len (tmr_len),
        .done(tmr_done)
    );

    nand_store #(
        .NUM_BLOCKS     (NUM_BLOCKS),
        .WORDS_PER_BLOCK(WORDS_PER_BLOCK)
    ) store_i (
        .clk      (clk),
        .rst      (rst),
        .wipe     (wipe),
        .corrupt  (corrupt),
        .blk      (blk),
        .peek_addr(peek_addr),
        .peek_data(peek_data)
    );

    assign rb_low = busy;
    assign dout   = (rd_en && stat_mode) ? status_byte(status) : 8'h00;

    // R9
    status_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && stat_mode) |-> (dout[6] == !rb_low));
    // R9
    dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (dout == 8'h00));

endmodule

// File: tb/nand_cmd_ctrl_tb.sv
module nand_cmd_ctrl_tb_top;
    localparam int NB   = 4;
    localparam int WPB  = 8;
    localparam int NW   = NB * WPB;
    localparam int ECYC = 24;
    localparam int RIC  = 5;
    localparam int REC  = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0, cle = 1'b0, ale = 1'b0, rd_en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, peek_data;
    logic       rb_low;
    logic [4:0] peek_addr = '0;

    int  checks = 0;
    int  failures = 0;
    bit  done_flag = 0;
    logic [7:0] exp_mem [NW];
    bit         unk [NW];

    always #5 clk = ~clk;

    nand_cmd_ctrl #(
        .NUM_BLOCKS(NB), .WORDS_PER_BLOCK(WPB),
        .ERASE_CYC(ECYC), .RST_IDLE_CYC(RIC), .RST_ERASE_CYC(REC)
    ) dut_i (
        .clk(clk), .rst(rst), .we(we), .cle(cle), .ale(ale), .din(din),
        .rd_en(rd_en), .dout(dout), .rb_low(rb_low),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; cle = c; ale = a; din = d;
        @(negedge clk);
        we = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d);
        wr(1'b1, 1'b0, d);
    endtask

    task automatic adr(input logic [7:0] d);
        wr(1'b0, 1'b1, d);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (rb_low && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_array(input string tag);
        for (int a = 0; a < NW; a++) begin
            peek_addr = 5'(a);
            #1;
            if (unk[a])
                chk(peek_data == exp_mem[a] || peek_data == 8'hFF, tag, peek_data, exp_mem[a]);
            else
                chk(peek_data == exp_mem[a], tag, peek_data, exp_mem[a]);
        end
    endtask

    task automatic read_status(input string tag, input logic [7:0] expv);
        cmd(8'h70);
        rd_en = 1'b1;
        #1;
        chk(dout == expv, tag, dout, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        for (int a = 0; a < NW; a++) begin
            exp_mem[a] = 8'(a) ^ 8'h5A;
            unk[a] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(rb_low == 1'b0, "R1 ready after reset", rb_low, 0);
        chk(dout == 8'h00, "R1 dout idle", dout, 0);
        check_array("R1 init array");
        read_status("R1 status after reset", 8'h40);
        rd_en = 1'b0;

        // R8 reset while in reset state
        cmd(8'hFF);
        chk(rb_low == 1'b0, "R8 reset ignored after power-up", rb_low, 0);
        repeat (3) @(negedge clk);
        chk(rb_low == 1'b0, "R8 still ready", rb_low, 0);

        // R10 both qualifiers high
        wr(1'b1, 1'b1, 8'h60);
        adr(8'h01); adr(8'h00); cmd(8'hD0);
        chk(rb_low == 1'b0, "R10 dual strobe ignored", rb_low, 0);
        check_array("R10 array unchanged");

        // R5 wrong confirm code
        cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'h30);
        chk(rb_low == 1'b0, "R5 wrong confirm no busy", rb_low, 0);
        cmd(8'hD0);
        chk(rb_low == 1'b0, "R5 late confirm no busy", rb_low, 0);
        check_array("R5 array unchanged");

        // R4 nonzero second address byte
        cmd(8'h60); adr(8'h01); adr(8'h08); cmd(8'hD0);
        count_busy(n);
        chk(n == ECYC, "R4 bad address busy length", n, ECYC);
        check_array("R4 array unchanged");
        read_status("R4 fail bit set", 8'h41);
        rd_en = 1'b0;

        // R7 reset while idle and not in reset state
        cmd(8'hFF);
        count_busy(n);
        chk(n == RIC, "R7 idle reset busy length", n, RIC);
        read_status("R7 fail cleared", 8'h40);
        rd_en = 1'b0;

        // R8 reset right after a completed reset
        cmd(8'hFF);
        chk(rb_low == 1'b0, "R8 reset ignored after reset", rb_low, 0);

        // R6 abort of a running erase on block 2
        cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
        repeat (4) @(negedge clk);
        read_status("R9 status while busy", 8'h00);
        rd_en = 1'b0;
        cmd(8'hFF);
        count_busy(n);
        chk(n == REC, "R6 abort reset busy length", n, REC);
        for (int w = 0; w < WPB; w++) unk[2 * WPB + w] = 1'b1;
        check_array("R6 abort leaves old or ones");
        read_status("R6 status after abort", 8'h40);
        rd_en = 1'b0;

        // R2 R3 sweep over all blocks, with high address bits varied
        for (int b = 0; b < NB; b++) begin
            logic [7:0] a1;
            a1 = 8'((b * 8'h24) & 8'hFC) | 8'(b);
            cmd(8'h60); adr(a1); adr(8'h00); cmd(8'hD0);
            count_busy(n);
            chk(n == ECYC, "R3 erase busy length", n, ECYC);
            for (int w = 0; w < WPB; w++) begin
                exp_mem[b * WPB + w] = 8'hFF;
                unk[b * WPB + w] = 1'b0;
            end
            check_array("R2 block erased, others intact");
            read_status("R4 pass after valid erase", 8'h40);
            rd_en = 1'b0;
        end

        // R9 status tracks completion without toggling rd_en
        rd_en = 1'b1;
        cmd(8'h60);
        #1;
        chk(dout == 8'h00, "R9 status deselected by setup", dout, 0);
        adr(8'h03); adr(8'h00); cmd(8'hD0);
        cmd(8'h70);
        #1;
        chk(dout == 8'h00, "R9 busy status", dout, 8'h00);
        count_busy(n);
        #1;
        chk(dout == 8'h40, "R9 ready status without toggle", dout, 8'h40);
        rd_en = 1'b0;
        #1;
        chk(dout == 8'h00, "R9 dout quiet when deselected", dout, 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule